// File: doc/BRIEF.md
# DMA Transfer Length Counter with Shadow Registers

This block holds the transfer length for the DMA engine of a SCSI host adapter. Software programs a 24-bit byte count through three byte-wide registers: low, middle and high. Those writes land only in shadow registers. The live counter, which is what software reads back, takes the shadow values only when a command arrives with its DMA flag set. A transfer command with the DMA flag asks the block to work out the effective length, pulse a start strobe and present that length to the data mover. When the data mover reports completion, the block sets terminal count, raises a bus-service event and clears the live counter.

The effective length is the live count bounded by the magnitude of the signed pending transfer size. A live count of zero stands for 65536 bytes. In command-phase mode the bound is a fixed 32 bytes instead of the pending size. If a transfer command arrives while the external DMA-enable input is low, it waits and runs as soon as the enable is high. Until software first writes the high counter byte after reset, a read of that byte returns a fixed identification code in place of the counter contents.

Top module: `dma_xfer_counter`

## Requirements
- R1: After reset, reads of address 0 (low) and address 1 (middle) return 0, a read of address 2 (high) returns CHIP_ID, terminal count is 0, and neither xferStart nor busSvc is asserted.
- R2: The count is formed as low + middle<<8 + high<<16, where the low byte is at address 0, the middle byte at address 1 and the high byte at address 2.
- R3: A register write changes only the shadow byte. Reads return the live counter, which takes all three shadow bytes at the clock edge that captures a command with cmdDma=1.
- R4: A read of address 2 returns CHIP_ID until the first write to address 2 after reset. From then on it returns the live high byte.
- R5: A write to any of addresses 0 to 2 clears terminal count on the edge that captures it.
- R6: A command with cmdDma=1 and cmdXfer=1, issued while dmaEnable is high, produces a one-cycle xferStart. At the same time xferLen equals min(count, |pendSize|) and terminal count is cleared.
- R7: A live count of zero is used as 65536 when computing the transfer length.
- R8: With cmdPhase=1, the transfer length is min(count, 32). pendSize is ignored.
- R9: A dmaDone pulse sets terminal count, gives a one-cycle busSvc (bus-service interrupt plus clearing of the sequence step and FIFO flags), and makes all three counter bytes read zero.
- R10: A transfer command captured while dmaEnable is low does not start. It stays pending, and xferStart follows one edge after dmaEnable is seen high.
- R11: A command with cmdDma=0 neither loads the live counter nor starts a transfer. A DMA command with cmdXfer=0 loads the counter but does not start a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regWrAddr | input | 2 | Write address: 0 low, 1 middle, 2 high |
| regWrData | input | 8 | Write data |
| regRdAddr | input | 2 | Read address |
| regRdData | output | 8 | Read data: live counter byte, or CHIP_ID |
| cmdStrobe | input | 1 | Command write strobe |
| cmdDma | input | 1 | DMA flag of the command |
| cmdXfer | input | 1 | Command is a transfer-information command |
| cmdPhase | input | 1 | Command-phase mode: bound the length at 32 |
| pendSize | input | 25 | Signed pending transfer size |
| dmaEnable | input | 1 | External DMA enable |
| dmaDone | input | 1 | DMA completion pulse |
| xferStart | output | 1 | One-cycle transfer start |
| xferLen | output | 25 | Effective length of the last started transfer |
| tcFlag | output | 1 | Terminal-count status |
| busSvc | output | 1 | One-cycle bus-service event |

## Verification
Read data is combinational from registers, so a write or command shows on regRdData after the single edge that captures it. terminal count and busSvc also follow one edge after their cause. xferStart and xferLen come two edges after an enabled transfer command: one edge to capture the command, one to run it. With enable low, they come one edge after the enable is seen high. The bench drives every input at a falling edge and samples 1 ns after the rising edge on which each result is due. It also checks that the start strobe is still low on every edge where a held command must wait.

// File: rtl/dmacnt_pkg.sv
package dmacnt_pkg;
  typedef struct packed {
    logic loadLive;
    logic zeroLive;
    logic runXfer;
    logic phaseMode;
  } ctlStrobe_t;
endpackage

// File: rtl/dma_xfer_counter_dp.sv
module dma_xfer_counter_dp
  import dmacnt_pkg::*;
#(
  parameter int CNT_BYTES = 3,
  parameter logic [7:0] CHIP_ID = 8'hA2,
  parameter int CMD_LIMIT = 32,
  parameter int ZERO_LEN = 65536,
  parameter int ADDR_W = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic regWrEn,
  input  logic [ADDR_W-1:0] regWrAddr,
  input  logic [7:0] regWrData,
  input  logic [ADDR_W-1:0] regRdAddr,
  input  logic idWritten,
  input  ctlStrobe_t strobe,
  input  logic signed [CNT_BYTES*8:0] pendSize,
  output logic [7:0] regRdData,
  output logic [CNT_BYTES*8:0] xferLen
);
  localparam int CNT_W = CNT_BYTES * 8;
  localparam int HI_IDX = CNT_BYTES - 1;

  logic [CNT_W-1:0] shadowQ;
  logic [CNT_W-1:0] liveQ;
  logic [7:0] liveBytes [CNT_BYTES];
  logic [CNT_W:0] xferLenQ;

  // shadow bytes: host writes land here only
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowQ <= '0;
    end else if (regWrEn) begin
      for (int b = 0; b < CNT_BYTES; b++) begin
        if (regWrAddr == ADDR_W'(b)) shadowQ[b*8 +: 8] <= regWrData;
      end
    end
  end

  // live counter: completion zeroes it, a DMA command reloads it
  always_ff @(posedge clk) begin
    if (!rstN) liveQ <= '0;
    else if (strobe.zeroLive) liveQ <= '0;
    else if (strobe.loadLive) liveQ <= shadowQ;
  end

  for (genvar g = 0; g < CNT_BYTES; g++) begin : g_bytes
    assign liveBytes[g] = liveQ[g*8 +: 8];
  end

  always_comb begin
    regRdData = '0;
    for (int b = 0; b < CNT_BYTES; b++) begin
      if (regRdAddr == ADDR_W'(b)) regRdData = liveBytes[b];
    end
    if (regRdAddr == ADDR_W'(HI_IDX) && !idWritten) regRdData = CHIP_ID;
  end

  // effective length
  logic [CNT_W:0] absPend, cntEff, bound, lenNext;
  always_comb begin
    absPend = pendSize[CNT_W] ? unsigned'(-pendSize) : unsigned'(pendSize);
    cntEff  = (liveQ == '0) ? (CNT_W+1)'(ZERO_LEN) : {1'b0, liveQ};
    bound   = strobe.phaseMode ? (CNT_W+1)'(CMD_LIMIT) : absPend;
    lenNext = (cntEff < bound) ? cntEff : bound;
  end

  always_ff @(posedge clk) begin
    if (!rstN) xferLenQ <= '0;
    else if (strobe.runXfer) xferLenQ <= lenNext;
  end

  assign xferLen = xferLenQ;

  p_zero_on_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.zeroLive |=> (liveQ == '0));
  p_load_from_shadow_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadLive && !strobe.zeroLive) |=> (liveQ == $past(shadowQ)));
  p_phase_limit_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.runXfer && strobe.phaseMode) |=> (xferLenQ <= (CNT_W+1)'(CMD_LIMIT)));
  p_len_nonzero_count_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.runXfer && !strobe.phaseMode && liveQ == '0 && absPend >= (CNT_W+1)'(ZERO_LEN))
    |=> (xferLenQ == (CNT_W+1)'(ZERO_LEN)));
endmodule

// File: rtl/dma_xfer_counter_ctrl.sv
module dma_xfer_counter_ctrl
  import dmacnt_pkg::*;
#(
  parameter int CNT_BYTES = 3,
  parameter int ADDR_W = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic regWrEn,
  input  logic [ADDR_W-1:0] regWrAddr,
  input  logic cmdStrobe,
  input  logic cmdDma,
  input  logic cmdXfer,
  input  logic cmdPhase,
  input  logic dmaEnable,
  input  logic dmaDone,
  output ctlStrobe_t strobe,
  output logic idWritten,
  output logic tcFlag,
  output logic xferStart,
  output logic busSvc
);
  localparam int HI_IDX = CNT_BYTES - 1;

  logic pendQ, pendPhaseQ, tcQ, idWrittenQ, xferStartQ, busSvcQ;
  logic cntWrite, runXfer;

  assign cntWrite = regWrEn && (regWrAddr < ADDR_W'(CNT_BYTES));
  assign runXfer  = pendQ && dmaEnable;

  always_comb begin
    strobe.loadLive  = cmdStrobe && cmdDma;
    strobe.zeroLive  = dmaDone;
    strobe.runXfer   = runXfer;
    strobe.phaseMode = pendPhaseQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ      <= 1'b0;
      pendPhaseQ <= 1'b0;
      tcQ        <= 1'b0;
      idWrittenQ <= 1'b0;
      xferStartQ <= 1'b0;
      busSvcQ    <= 1'b0;
    end else begin
      if (cmdStrobe) begin
        pendQ      <= cmdDma && cmdXfer;
        pendPhaseQ <= cmdPhase;
      end else if (runXfer) begin
        pendQ <= 1'b0;
      end
      if (dmaDone) tcQ <= 1'b1;
      else if (cntWrite || runXfer) tcQ <= 1'b0;
      if (regWrEn && regWrAddr == ADDR_W'(HI_IDX)) idWrittenQ <= 1'b1;
      xferStartQ <= runXfer;
      busSvcQ    <= dmaDone;
    end
  end

  assign idWritten = idWrittenQ;
  assign tcFlag    = tcQ;
  assign xferStart = xferStartQ;
  assign busSvc    = busSvcQ;

  p_tc_set_on_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    dmaDone |=> (tcQ && busSvcQ));
  p_write_clears_tc_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cntWrite && !dmaDone) |=> !tcQ);
  p_start_clears_tc_r6: assert property (@(posedge clk) disable iff (!rstN)
    (xferStartQ && !$past(dmaDone)) |-> !tcQ);
  p_held_while_disabled_r10: assert property (@(posedge clk) disable iff (!rstN)
    !dmaEnable |=> !xferStartQ);
  p_id_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    idWrittenQ |=> idWrittenQ);
endmodule

// File: rtl/dma_xfer_counter.sv
module dma_xfer_counter
  import dmacnt_pkg::*;
#(
  parameter int CNT_BYTES = 3,
  parameter logic [7:0] CHIP_ID = 8'hA2,
  parameter int CMD_LIMIT = 32,
  parameter int ZERO_LEN = 65536,
  localparam int ADDR_W = $clog2(CNT_BYTES + 1),
  localparam int CNT_W = CNT_BYTES * 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic regWrEn,
  input  logic [ADDR_W-1:0] regWrAddr,
  input  logic [7:0] regWrData,
  input  logic [ADDR_W-1:0] regRdAddr,
  output logic [7:0] regRdData,
  input  logic cmdStrobe,
  input  logic cmdDma,
  input  logic cmdXfer,
  input  logic cmdPhase,
  input  logic signed [CNT_W:0] pendSize,
  input  logic dmaEnable,
  input  logic dmaDone,
  output logic xferStart,
  output logic [CNT_W:0] xferLen,
  output logic tcFlag,
  output logic busSvc
);
  ctlStrobe_t strobe;
  logic idWritten;

  dma_xfer_counter_ctrl #(.CNT_BYTES(CNT_BYTES), .ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrAddr(regWrAddr),
    .cmdStrobe(cmdStrobe), .cmdDma(cmdDma), .cmdXfer(cmdXfer), .cmdPhase(cmdPhase),
    .dmaEnable(dmaEnable), .dmaDone(dmaDone), .strobe(strobe), .idWritten(idWritten),
    .tcFlag(tcFlag), .xferStart(xferStart), .busSvc(busSvc)
  );

  dma_xfer_counter_dp #(.CNT_BYTES(CNT_BYTES), .CHIP_ID(CHIP_ID), .CMD_LIMIT(CMD_LIMIT),
                        .ZERO_LEN(ZERO_LEN), .ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrAddr(regWrAddr),
    .regWrData(regWrData), .regRdAddr(regRdAddr), .idWritten(idWritten),
    .strobe(strobe), .pendSize(pendSize), .regRdData(regRdData), .xferLen(xferLen)
  );
endmodule

// File: tb/dma_xfer_counter_tb.sv
module dma_xfer_counter_tb_top;
  localparam logic [7:0] CHIP_ID = 8'hA2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [1:0] regWrAddr = '0;
  logic [7:0] regWrData = '0;
  logic [1:0] regRdAddr = '0;
  logic [7:0] regRdData;
  logic cmdStrobe = 1'b0, cmdDma = 1'b0, cmdXfer = 1'b0, cmdPhase = 1'b0;
  logic signed [24:0] pendSize = '0;
  logic dmaEnable = 1'b1;
  logic dmaDone = 1'b0;
  logic xferStart;
  logic [24:0] xferLen;
  logic tcFlag, busSvc;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // bench model
  logic [23:0] mShadow = '0;
  logic [23:0] mLive = '0;
  bit mIdW = 0;
  bit mTc = 0;

  always #4 clk = ~clk;

  dma_xfer_counter #(.CHIP_ID(CHIP_ID)) dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrAddr(regWrAddr),
    .regWrData(regWrData), .regRdAddr(regRdAddr), .regRdData(regRdData),
    .cmdStrobe(cmdStrobe), .cmdDma(cmdDma), .cmdXfer(cmdXfer), .cmdPhase(cmdPhase),
    .pendSize(pendSize), .dmaEnable(dmaEnable), .dmaDone(dmaDone),
    .xferStart(xferStart), .xferLen(xferLen), .tcFlag(tcFlag), .busSvc(busSvc)
  );

  function automatic logic [24:0] effLen(logic [23:0] live, logic signed [24:0] pend, bit phase);
    logic [24:0] c, a, bnd;
    c = (live == 0) ? 25'd65536 : {1'b0, live};
    a = (pend < 0) ? 25'(-pend) : 25'(pend);
    bnd = phase ? 25'd32 : a;
    return (c < bnd) ? c : bnd;
  endfunction

  function automatic logic [7:0] expRead(logic [1:0] a);
    if (a == 2'd2 && !mIdW) return CHIP_ID;
    if (a == 2'd3) return 8'h00;
    return mLive[a*8 +: 8];
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic checkReads(string tag);
    for (int a = 0; a < 4; a++) begin
      regRdAddr = 2'(a);
      #1;
      chk(regRdData == expRead(2'(a)), tag, regRdData, expRead(2'(a)));
    end
  endtask

  task automatic wrReg(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regWrAddr = a; regWrData = d;
    @(posedge clk); #1;
    regWrEn = 1'b0;
    if (a != 2'd3) begin mShadow[a*8 +: 8] = d; mTc = 0; end
    if (a == 2'd2) mIdW = 1;
    chk(tcFlag == mTc, "R5 tc after write", tcFlag, mTc);
  endtask

  task automatic doDone();
    @(negedge clk);
    dmaDone = 1'b1;
    @(posedge clk); #1;
    dmaDone = 1'b0;
    mLive = '0; mTc = 1;
    chk(busSvc == 1'b1, "R9 busSvc", busSvc, 1);
    chk(tcFlag == 1'b1, "R9 tc set", tcFlag, 1);
    @(posedge clk); #1;
    chk(busSvc == 1'b0, "R9 busSvc one cycle", busSvc, 0);
  endtask

  // issue command with enable high; checks start two edges later
  task automatic issueCmd(bit dma, bit xfer, bit phase, logic signed [24:0] pend, string tag);
    bit expStart;
    @(negedge clk);
    cmdStrobe = 1'b1; cmdDma = dma; cmdXfer = xfer; cmdPhase = phase; pendSize = pend;
    @(posedge clk); #1;
    cmdStrobe = 1'b0;
    if (dma) mLive = mShadow;
    @(posedge clk); #1;
    expStart = dma && xfer;
    chk(xferStart == expStart, {tag, " start"}, xferStart, expStart);
    if (expStart) begin
      mTc = 0;
      chk(xferLen == effLen(mLive, pend, phase), {tag, " len"}, xferLen, effLen(mLive, pend, phase));
      chk(tcFlag == 1'b0, "R6 tc cleared by start", tcFlag, 0);
    end
    @(posedge clk); #1;
    chk(xferStart == 1'b0, {tag, " start one cycle"}, xferStart, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    checkReads("R1 reset reads");
    chk(tcFlag == 0, "R1 tc", tcFlag, 0);
    chk(xferStart == 0, "R1 xferStart", xferStart, 0);
    chk(busSvc == 0, "R1 busSvc", busSvc, 0);

    // R3 shadows only
    wrReg(2'd0, 8'h34);
    wrReg(2'd1, 8'h12);
    checkReads("R3 shadow not visible");
    // R11 non-DMA command loads nothing
    issueCmd(0, 1, 0, 25'sd1000, "R11 non-DMA");
    checkReads("R11 live unchanged");
    // R3 DMA command loads; R4 id still shown
    issueCmd(1, 0, 0, 25'sd1000, "R11 DMA no xfer");
    checkReads("R3 R4 loaded");
    // R4 write high byte switches to live high byte
    wrReg(2'd2, 8'h05);
    checkReads("R4 after high write");
    // R2 composition
    issueCmd(1, 1, 0, 25'sh0FFFFFF, "R2 R6 full count");
    // R9 completion
    doDone();
    checkReads("R9 counter zero");
    // R5 write clears tc
    wrReg(2'd0, 8'h00);
    wrReg(2'd1, 8'h00);
    wrReg(2'd2, 8'h00);
    // R7 zero count
    issueCmd(1, 1, 0, -25'sh0020000, "R7 zero count");
    issueCmd(1, 1, 0, 25'sh0010001, "R7 zero count exact");
    // R8 phase mode
    wrReg(2'd1, 8'h01);
    issueCmd(1, 1, 1, 25'sd5, "R8 phase limit");
    wrReg(2'd1, 8'h00);
    wrReg(2'd0, 8'h10);
    issueCmd(1, 1, 1, 25'sd5, "R8 phase small count");
    // R6 start clears tc after done
    doDone();
    wrReg(2'd3, 8'hFF);
    chk(tcFlag == 1'b1, "R5 addr3 write keeps tc", tcFlag, 1);
    issueCmd(1, 1, 0, -25'sd7, "R6 negative pend");

    // R10 held while enable low
    @(negedge clk);
    dmaEnable = 1'b0;
    cmdStrobe = 1'b1; cmdDma = 1'b1; cmdXfer = 1'b1; cmdPhase = 1'b0; pendSize = 25'sd9;
    @(posedge clk); #1;
    cmdStrobe = 1'b0;
    mLive = mShadow;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1;
      chk(xferStart == 1'b0, "R10 held", xferStart, 0);
    end
    @(negedge clk);
    dmaEnable = 1'b1;
    @(posedge clk); #1;
    chk(xferStart == 1'b1, "R10 runs on enable", xferStart, 1);
    chk(xferLen == effLen(mLive, 25'sd9, 0), "R10 len", xferLen, effLen(mLive, 25'sd9, 0));
    mTc = 0;
    @(posedge clk); #1;
    chk(xferStart == 1'b0, "R10 single start", xferStart, 0);

    // random mix
    for (int it = 0; it < 60; it++) begin
      int nw;
      nw = $urandom_range(0, 3);
      for (int k = 0; k < nw; k++) wrReg(2'($urandom_range(0, 2)), 8'($urandom));
      if ($urandom_range(0, 3) == 0) wrReg(2'd1, 8'h00);
      issueCmd($urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0, $urandom_range(0, 4) == 0,
               25'($signed($urandom_range(0, 32'h1FFFFFF)) - 25'sh0800000), "R2 R6 random");
      checkReads("R3 random reads");
      if ($urandom_range(0, 4) == 0) doDone();
      chk(tcFlag == mTc, "R5 R9 random tc", tcFlag, mTc);
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule